// File: doc/BRIEF.md
# Mode Command Response Decider

This block sits in a remote terminal on a redundant serial command/response bus. It takes a command word that an upstream decoder has already taken apart, and decides how the terminal answers it. The inputs are the mode-code indication, the transmit/receive direction bit, the five-bit mode code, the number of data words that came with the command, and the command's terminal address. From these it makes one decision. The terminal may answer with its status word, answer with status followed by a word it holds internally, answer with status while fetching one word from the host, or stay silent and flag a message error. The decision is also shaped by a broadcast enable, the terminal's own hardwired address and a host-supplied illegal-command flag.

The terminal's hardwired address arrives with one parity pin. The block checks that address continuously and raises an address-error flag when a line is open or mis-strapped. The decision is presented one clock after the end-of-message strobe, as a one-cycle set of flags. The status-word formatter and the host transfer engine act on those flags.

Top module: `mode_resp_decider`

## Requirements
- R1: `addr_err` is high one cycle after the number of ones across `own_addr` and `addr_par` is even (odd parity expected), and it is re-evaluated every cycle.
- R2: A command is recognized when `cmd_addr` equals `own_addr`, or when `cmd_addr` is 31 (all ones) and `bcast_en` is high. With `bcast_en` low, address 31 is recognized only if it is the terminal's own address, and then it is not a broadcast.
- R3: A command that is not a mode command (`is_mode` low), or whose address is not recognized, produces no decision: `dec_valid` and all decision flags stay low.
- R4: A mode command with `tr_bit`=1 and `mode_code[4]`=0 answers with status only. This includes reserved codes.
- R5: A mode command with `tr_bit`=0 and `mode_code[4]`=0 is a direction error. It sets `msg_err`, `tr_err` and `status_suppress`, and sends no status.
- R6: A mode command with `tr_bit`=0 and `mode_code[4]`=1 answers with status only when exactly one data word came with it. A count of zero, or of two or more, sets `msg_err` and `status_suppress`.
- R7: A mode command with `tr_bit`=1 and `mode_code[4]`=1 whose code is neither 19 nor 18 answers with status and raises `host_req`.
- R8: Code 19 with `tr_bit`=1 answers with status plus `send_bitword`. Code 18 with `tr_bit`=1 answers with status plus `send_lastcmd`. Neither raises `host_req`.
- R9: When `illegal` is high and R5 or R6 has not already caused an error, the answer is status with `msg_err`. No host request is made and no internal word is sent.
- R10: A broadcast command raises `bcast_rx` and `status_suppress`, and drives `resp_status`, `host_req`, `send_bitword` and `send_lastcmd` low. `msg_err` and `tr_err` still follow R5, R6 and R9.
- R11: The decision flags are registered. They are high only in the cycle after `cmd_valid`, for one cycle, and reset clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | End-of-message strobe, one cycle |
| is_mode | input | 1 | Command is a mode command |
| tr_bit | input | 1 | Direction bit, 1 = terminal transmits |
| mode_code | input | 5 | Mode code; bit 4 marks codes that carry a data word |
| data_count | input | 6 | Data words received with the command |
| cmd_addr | input | 5 | Terminal address in the command |
| own_addr | input | 5 | Hardwired terminal address |
| addr_par | input | 1 | Hardwired parity pin for own_addr |
| bcast_en | input | 1 | Enables address 31 as broadcast |
| illegal | input | 1 | Host flags the command as illegal |
| dec_valid | output | 1 | Decision present this cycle |
| resp_status | output | 1 | Send the status word |
| status_suppress | output | 1 | Do not send status |
| msg_err | output | 1 | Set message error |
| host_req | output | 1 | Fetch one word from the host |
| send_bitword | output | 1 | Follow status with the self-test word |
| send_lastcmd | output | 1 | Follow status with the last command word |
| tr_err | output | 1 | Direction / mode-code error |
| bcast_rx | output | 1 | Command was a broadcast |
| addr_err | output | 1 | Hardwired address parity failure |

## Verification
The hardest cases to reach are those where two causes meet: a broadcast that is also illegal, and an illegal code that also has a direction or word-count error. Only precedence then separates a correct answer from a wrong one. The vector table places these combinations next to their single-cause versions, so that a reversed priority shows up as a specific flag mismatch. Directed steps then move the terminal's own address to 31 with broadcast disabled. They also break the address parity through the normal pins, which covers the cases a fixed own address cannot reach.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
   typedef struct packed {
      logic status;
      logic suppress;
      logic msg_err;
      logic host_req;
      logic bitword;
      logic lastcmd;
      logic tr_err;
      logic bcast;
   } mrd_dec_t;
endpackage

// File: rtl/mrd_addr_check.sv
module mrd_addr_check #(
   parameter int ADDR_W     = 5,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              addr_par,
   input  logic              bcast_en,
   output logic              hit,
   output logic              bcast,
   output logic              par_bad
);
   localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

   logic own_hit;
   logic all_ones;

   assign own_hit  = (cmd_addr == own_addr);
   assign all_ones = (cmd_addr == BCAST_ADDR);
   assign bcast    = bcast_en && all_ones;
   assign hit      = own_hit || bcast;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_bad = ~^{own_addr, addr_par};
      end else begin : g_even
         assign par_bad = ^{own_addr, addr_par};
      end
   endgenerate
endmodule

// File: rtl/mrd_mode_rules.sv
module mrd_mode_rules
   import mrd_pkg::*;
#(
   parameter int CODE_W       = 5,
   parameter int CNT_W        = 6,
   parameter int CODE_TX_BIT  = 19,
   parameter int CODE_TX_LAST = 18
) (
   input  logic              tr_bit,
   input  logic [CODE_W-1:0] mode_code,
   input  logic [CNT_W-1:0]  data_count,
   input  logic              illegal,
   input  logic              bcast,
   output mrd_dec_t          dec
);
   localparam logic [CODE_W-1:0] TX_BIT  = CODE_W'(CODE_TX_BIT);
   localparam logic [CODE_W-1:0] TX_LAST = CODE_W'(CODE_TX_LAST);
   localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

   logic with_word;
   assign with_word = mode_code[CODE_W-1];

   always_comb begin
      dec       = '0;
      dec.bcast = bcast;
      if (!with_word && !tr_bit) begin
         dec.msg_err  = 1'b1;
         dec.tr_err   = 1'b1;
         dec.suppress = 1'b1;
      end else if (with_word && !tr_bit && (data_count != ONE)) begin
         dec.msg_err  = 1'b1;
         dec.suppress = 1'b1;
      end else if (illegal) begin
         dec.status  = 1'b1;
         dec.msg_err = 1'b1;
      end else if (with_word && tr_bit) begin
         dec.status = 1'b1;
         if (mode_code == TX_BIT)       dec.bitword  = 1'b1;
         else if (mode_code == TX_LAST) dec.lastcmd  = 1'b1;
         else                           dec.host_req = 1'b1;
      end else begin
         dec.status = 1'b1;
      end
      if (bcast) begin
         dec.status   = 1'b0;
         dec.host_req = 1'b0;
         dec.bitword  = 1'b0;
         dec.lastcmd  = 1'b0;
         dec.suppress = 1'b1;
      end
   end
endmodule

// File: rtl/mode_resp_decider.sv
module mode_resp_decider
   import mrd_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int CODE_W       = 5,
   parameter int CNT_W        = 6,
   parameter int CODE_TX_BIT  = 19,
   parameter int CODE_TX_LAST = 18,
   parameter bit ODD_PARITY   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              is_mode,
   input  logic              tr_bit,
   input  logic [CODE_W-1:0] mode_code,
   input  logic [CNT_W-1:0]  data_count,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              addr_par,
   input  logic              bcast_en,
   input  logic              illegal,
   output logic              dec_valid,
   output logic              resp_status,
   output logic              status_suppress,
   output logic              msg_err,
   output logic              host_req,
   output logic              send_bitword,
   output logic              send_lastcmd,
   output logic              tr_err,
   output logic              bcast_rx,
   output logic              addr_err
);
   localparam int CODE_SPAN = 1 << CODE_W;

   generate
      if (CODE_W < 2) begin : g_bad_code_w
         $error("CODE_W must be at least 2");
      end
      if (CODE_TX_BIT >= CODE_SPAN || CODE_TX_LAST >= CODE_SPAN) begin : g_bad_codes
         $error("special mode codes exceed CODE_W");
      end
      if (CODE_TX_BIT == CODE_TX_LAST) begin : g_same_codes
         $error("special mode codes must differ");
      end
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic     hit;
   logic     bcast;
   logic     par_bad;
   logic     take;
   mrd_dec_t dec_d;
   mrd_dec_t dec_q;
   logic     dv_q;
   logic     aerr_q;

   mrd_addr_check #(
      .ADDR_W     (ADDR_W),
      .ODD_PARITY (ODD_PARITY)
   ) u_addr (
      .cmd_addr (cmd_addr),
      .own_addr (own_addr),
      .addr_par (addr_par),
      .bcast_en (bcast_en),
      .hit      (hit),
      .bcast    (bcast),
      .par_bad  (par_bad)
   );

   mrd_mode_rules #(
      .CODE_W       (CODE_W),
      .CNT_W        (CNT_W),
      .CODE_TX_BIT  (CODE_TX_BIT),
      .CODE_TX_LAST (CODE_TX_LAST)
   ) u_rules (
      .tr_bit     (tr_bit),
      .mode_code  (mode_code),
      .data_count (data_count),
      .illegal    (illegal),
      .bcast      (bcast),
      .dec        (dec_d)
   );

   assign take = cmd_valid && is_mode && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dv_q   <= 1'b0;
         dec_q  <= '0;
         aerr_q <= 1'b0;
      end else begin
         dv_q   <= take;
         dec_q  <= take ? dec_d : '0;
         aerr_q <= par_bad;
      end
   end

   assign dec_valid       = dv_q;
   assign resp_status     = dec_q.status;
   assign status_suppress = dec_q.suppress;
   assign msg_err         = dec_q.msg_err;
   assign host_req        = dec_q.host_req;
   assign send_bitword    = dec_q.bitword;
   assign send_lastcmd    = dec_q.lastcmd;
   assign tr_err          = dec_q.tr_err;
   assign bcast_rx        = dec_q.bcast;
   assign addr_err        = aerr_q;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
   parameter int ADDR_W     = 5,
   parameter int CODE_W     = 5,
   parameter int CNT_W      = 6,
   parameter bit ODD_PARITY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              is_mode,
   input logic              tr_bit,
   input logic [CODE_W-1:0] mode_code,
   input logic [CNT_W-1:0]  data_count,
   input logic [ADDR_W-1:0] own_addr,
   input logic              addr_par,
   input logic              dec_valid,
   input logic              resp_status,
   input logic              status_suppress,
   input logic              msg_err,
   input logic              host_req,
   input logic              send_bitword,
   input logic              send_lastcmd,
   input logic              tr_err,
   input logic              bcast_rx,
   input logic              addr_err
);
   logic par_ok_now;
   assign par_ok_now = ODD_PARITY ? (^{own_addr, addr_par}) : ~(^{own_addr, addr_par});

   AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (addr_err == !$past(par_ok_now)));                              // R1
   AST_DV_NEEDS_MODE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(cmd_valid && is_mode));                                      // R3
   AST_DIR_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_valid && is_mode && !tr_bit && !mode_code[CODE_W-1]) |-> !resp_status); // R5
   AST_COUNT_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_valid && is_mode && !tr_bit && mode_code[CODE_W-1] && data_count != CNT_W'(1))
      |-> !resp_status);                                                               // R6
   AST_HOST_REQ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      host_req |-> (resp_status && !msg_err && !send_bitword && !send_lastcmd));       // R7
   AST_ONE_INTERNAL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({send_bitword, send_lastcmd, host_req}));                               // R8
   AST_TR_ERR_WITH_ME: assert property (@(posedge clk) disable iff (!rst_n)
      tr_err |-> (msg_err && status_suppress));                                        // R5
   AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_rx |-> (!resp_status && status_suppress));                                 // R10
   AST_FLAGS_NEED_DV: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !(resp_status || status_suppress || msg_err || bcast_rx));        // R11
   AST_STATUS_XOR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (resp_status != status_suppress));                                 // R11
endmodule

bind mode_resp_decider mrd_checker #(
   .ADDR_W     (ADDR_W),
   .CODE_W     (CODE_W),
   .CNT_W      (CNT_W),
   .ODD_PARITY (ODD_PARITY)
) u_mrd_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .cmd_valid       (cmd_valid),
   .is_mode         (is_mode),
   .tr_bit          (tr_bit),
   .mode_code       (mode_code),
   .data_count      (data_count),
   .own_addr        (own_addr),
   .addr_par        (addr_par),
   .dec_valid       (dec_valid),
   .resp_status     (resp_status),
   .status_suppress (status_suppress),
   .msg_err         (msg_err),
   .host_req        (host_req),
   .send_bitword    (send_bitword),
   .send_lastcmd    (send_lastcmd),
   .tr_err          (tr_err),
   .bcast_rx        (bcast_rx),
   .addr_err        (addr_err)
);

// File: tb/mode_resp_decider_bench.sv
module mode_resp_decider_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_valid, is_mode, tr_bit, addr_par, bcast_en, illegal;
   logic [4:0] mode_code, cmd_addr, own_addr;
   logic [5:0] data_count;
   logic       dec_valid, resp_status, status_suppress, msg_err, host_req;
   logic       send_bitword, send_lastcmd, tr_err, bcast_rx, addr_err;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   mode_resp_decider u_mode_resp_decider (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .is_mode (is_mode),
      .tr_bit (tr_bit), .mode_code (mode_code), .data_count (data_count),
      .cmd_addr (cmd_addr), .own_addr (own_addr), .addr_par (addr_par),
      .bcast_en (bcast_en), .illegal (illegal), .dec_valid (dec_valid),
      .resp_status (resp_status), .status_suppress (status_suppress),
      .msg_err (msg_err), .host_req (host_req), .send_bitword (send_bitword),
      .send_lastcmd (send_lastcmd), .tr_err (tr_err), .bcast_rx (bcast_rx),
      .addr_err (addr_err)
   );

   // fields: is_mode tr code[5] cnt[6] addr[5] bcast_en illegal | dv st sup me hr bw lc tre bc
   localparam int NV = 18;
   localparam logic [28:0] VEC [NV] = '{
      {1'b1, 1'b1, 5'd2,  6'd0, 5'd5,  1'b0, 1'b0, 9'b110000000}, // R4
      {1'b1, 1'b1, 5'd15, 6'd0, 5'd5,  1'b0, 1'b0, 9'b110000000}, // R4 reserved
      {1'b1, 1'b0, 5'd1,  6'd0, 5'd5,  1'b0, 1'b0, 9'b101100010}, // R5
      {1'b1, 1'b0, 5'd17, 6'd1, 5'd5,  1'b0, 1'b0, 9'b110000000}, // R6 one word
      {1'b1, 1'b0, 5'd17, 6'd0, 5'd5,  1'b0, 1'b0, 9'b101100000}, // R6 none
      {1'b1, 1'b0, 5'd17, 6'd2, 5'd5,  1'b0, 1'b0, 9'b101100000}, // R6 too many
      {1'b1, 1'b1, 5'd16, 6'd0, 5'd5,  1'b0, 1'b0, 9'b110010000}, // R7
      {1'b1, 1'b1, 5'd19, 6'd0, 5'd5,  1'b0, 1'b0, 9'b110001000}, // R8 bit word
      {1'b1, 1'b1, 5'd18, 6'd0, 5'd5,  1'b0, 1'b0, 9'b110000100}, // R8 last cmd
      {1'b1, 1'b1, 5'd16, 6'd0, 5'd5,  1'b0, 1'b1, 9'b110100000}, // R9
      {1'b1, 1'b1, 5'd2,  6'd0, 5'd31, 1'b1, 1'b0, 9'b101000001}, // R10
      {1'b1, 1'b0, 5'd17, 6'd1, 5'd31, 1'b1, 1'b0, 9'b101000001}, // R10
      {1'b1, 1'b1, 5'd2,  6'd0, 5'd31, 1'b0, 1'b0, 9'b000000000}, // R2 bcast off
      {1'b1, 1'b1, 5'd2,  6'd0, 5'd6,  1'b0, 1'b0, 9'b000000000}, // R3 other addr
      {1'b0, 1'b1, 5'd2,  6'd0, 5'd5,  1'b0, 1'b0, 9'b000000000}, // R3 not mode
      {1'b1, 1'b0, 5'd1,  6'd0, 5'd5,  1'b0, 1'b1, 9'b101100010}, // R9 error wins
      {1'b1, 1'b0, 5'd17, 6'd1, 5'd31, 1'b1, 1'b1, 9'b101100001}, // R10 + illegal
      {1'b1, 1'b0, 5'd17, 6'd1, 5'd5,  1'b0, 1'b1, 9'b110100000}  // R9 receive
   };

   function automatic logic [8:0] outs();
      return {dec_valid, resp_status, status_suppress, msg_err, host_req,
              send_bitword, send_lastcmd, tr_err, bcast_rx};
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic issue(input logic [19:0] v);
      @(negedge clk);
      {is_mode, tr_bit, mode_code, data_count, cmd_addr, bcast_en, illegal} = v;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; is_mode = 1'b0; tr_bit = 1'b0;
      mode_code = '0; data_count = '0; cmd_addr = '0; bcast_en = 1'b0; illegal = 1'b0;
      own_addr = 5'd5; addr_par = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 reset", outs(), 9'b0);
      check("R1 reset", {8'b0, addr_err}, 9'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][28:9]);
         check($sformatf("R4-table vector %0d", i), outs(), VEC[i][8:0]);
      end

      // R11: one-cycle pulse
      issue({1'b1, 1'b1, 5'd16, 6'd0, 5'd5, 1'b0, 1'b0});
      check("R7 before pulse end", outs(), 9'b110010000);
      @(negedge clk);
      check("R11 pulse ends", outs(), 9'b0);

      // R2: own address 31 with broadcast disabled is a plain own hit
      own_addr = 5'd31; addr_par = 1'b0;
      issue({1'b1, 1'b1, 5'd2, 6'd0, 5'd31, 1'b0, 1'b0});
      check("R2 own addr 31", outs(), 9'b110000000);
      check("R1 good parity at 31", {8'b0, addr_err}, 9'b0);

      // R1: parity failure, then recovery
      own_addr = 5'd5; addr_par = 1'b0;
      @(negedge clk);
      check("R1 parity fail", {8'b0, addr_err}, 9'b1);
      addr_par = 1'b1;
      @(negedge clk);
      check("R1 parity restored", {8'b0, addr_err}, 9'b0);

      // R3: idle cycles give no decision
      @(negedge clk);
      check("R3 idle", outs(), 9'b0);

      finish_run();
   end
endmodule